// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory uses on each clock. A load command with the chip selected captures a full external address and starts a burst of four beats. Each later advance command steps only the two lowest address bits to the next beat. The upper bits stay as they were captured.

A static order input picks the stepping pattern. In linear order the low bits count upward and wrap modulo four. In interleaved order the beat number is XORed with the low bits that were captured at load time. A load command with the chip deselected ends the burst. A high active-low clock enable freezes every register for that edge. The memory array, the data path and the output drivers sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: With `rst` high at a clock edge, `addr` becomes 0 and `burst_active` becomes 0 after that edge, whatever the other inputs are.
- R2: `clk_en_n`=0, `ld_adv_n`=0 and `sel`=1 at an edge load `ext_addr` into `addr` and set `burst_active` to 1.
- R3: An advance (`clk_en_n`=0, `ld_adv_n`=1) during an active burst leaves `addr[AW-1:2]` unchanged and does not look at `ext_addr`.
- R4: With `order_il`=0 (linear), the k-th advance after a load gives `addr[1:0]` = (start + k) mod 4, where start is the loaded `ext_addr[1:0]`.
- R5: With `order_il`=1 (interleaved), the k-th advance after a load gives `addr[1:0]` = start XOR (k mod 4).
- R6: After four advances `addr` is back at the loaded address and the burst keeps cycling. No carry ever reaches `addr[AW-1:2]`.
- R7: `clk_en_n`=0, `ld_adv_n`=0 and `sel`=0 clear `burst_active` and leave `addr` unchanged.
- R8: With `clk_en_n`=1, `addr` and `burst_active` keep their values, whatever `ld_adv_n`, `sel` and `ext_addr` are.
- R9: An advance while `burst_active`=0 leaves `addr` unchanged and `burst_active` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| ld_adv_n | input | 1 | Low: load or deselect; high: advance |
| sel | input | 1 | Chip selected, already qualified by the chip enables |
| ext_addr | input | AW (17) | External address captured on load |
| order_il | input | 1 | Static burst order: 1 interleaved, 0 linear |
| addr | output | AW (17) | Current internal address |
| burst_active | output | 1 | A burst is in progress |

## Verification
The bench goes after the wrap at the fourth beat. It loads an address whose low bits are 3 and whose upper bits are all ones. A design that carries into the upper bits, or that stops at the last beat, shows the wrong address there. Both orders are run from non-zero start bits, because a design that mixes up add and XOR only shows it when the start bits are non-zero. The bench also changes `ext_addr` during advances and holds the clock enable high while a load is requested. A design that reloads on advance, or that ignores the enable, takes the new address. Last, it advances after a deselect. A design that does not clear the burst keeps stepping the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_LOAD = 2'd1,
        CMD_STOP = 2'd2,
        CMD_STEP = 2'd3
    } seq_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
    import burst_seq_pkg::*;
(
    input  logic     clk_en_n,
    input  logic     ld_adv_n,
    input  logic     sel,
    input  logic     active,
    output seq_cmd_e cmd
);
    always_comb begin
        cmd = CMD_HOLD;
        if (!clk_en_n) begin
            if (!ld_adv_n) begin
                cmd = sel ? CMD_LOAD : CMD_STOP;
            end else if (active) begin
                cmd = CMD_STEP;
            end
        end
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int BEAT_BITS = 2
) (
    input  logic [BEAT_BITS-1:0] start,
    input  logic [BEAT_BITS-1:0] beat,
    input  logic                 order_il,
    output logic [BEAT_BITS-1:0] low
);
    logic [BEAT_BITS-1:0] lin_low;
    logic [BEAT_BITS-1:0] il_low;

    assign lin_low = start + beat;

    for (genvar b = 0; b < BEAT_BITS; b++) begin : g_xor
        assign il_low[b] = start[b] ^ beat[b];
    end

    assign low = order_il ? il_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int AW        = 17,
    parameter int BEAT_BITS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en_n,
    input  logic          ld_adv_n,
    input  logic          sel,
    input  logic [AW-1:0] ext_addr,
    input  logic          order_il,
    output logic [AW-1:0] addr,
    output logic          burst_active
);
    localparam int UPPER_W = AW - BEAT_BITS;

    typedef struct packed {
        logic [UPPER_W-1:0]   upper;
        logic [BEAT_BITS-1:0] low;
        logic [BEAT_BITS-1:0] start;
        logic [BEAT_BITS-1:0] beat;
        logic                 active;
    } seq_state_t;

    seq_state_t           st_d, st_q;
    seq_cmd_e             cmd;
    logic [BEAT_BITS-1:0] beat_next;
    logic [BEAT_BITS-1:0] low_next;

    burst_cmd_decode u_dec (
        .clk_en_n (clk_en_n),
        .ld_adv_n (ld_adv_n),
        .sel      (sel),
        .active   (st_q.active),
        .cmd      (cmd)
    );

    assign beat_next = st_q.beat + {{(BEAT_BITS-1){1'b0}}, 1'b1};

    burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
        .start    (st_q.start),
        .beat     (beat_next),
        .order_il (order_il),
        .low      (low_next)
    );

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.upper  = ext_addr[AW-1:BEAT_BITS];
                st_d.low    = ext_addr[BEAT_BITS-1:0];
                st_d.start  = ext_addr[BEAT_BITS-1:0];
                st_d.beat   = '0;
                st_d.active = 1'b1;
            end
            CMD_STOP: begin
                st_d.active = 1'b0;
            end
            CMD_STEP: begin
                st_d.beat = beat_next;
                st_d.low  = low_next;
            end
            default: begin
                st_d = st_q;
            end
        endcase
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr         = {st_q.upper, st_q.low};
    assign burst_active = st_q.active;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int AW        = 17,
    parameter int BEAT_BITS = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en_n,
    input logic          ld_adv_n,
    input logic          sel,
    input logic [AW-1:0] ext_addr,
    input logic          order_il,
    input logic [AW-1:0] addr,
    input logic          burst_active
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (addr == '0 && !burst_active)); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_adv_n && sel) |=> (addr == $past(ext_addr) && burst_active)); // R2

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_adv_n) |=> $stable(addr[AW-1:BEAT_BITS])); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_adv_n && burst_active && !order_il) |=>
        (addr[BEAT_BITS-1:0] == ($past(addr[BEAT_BITS-1:0]) + {{(BEAT_BITS-1){1'b0}}, 1'b1}))); // R4

    AST_DESELECT_STOP: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_adv_n && !sel) |=> (!burst_active && $stable(addr))); // R7

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(addr) && $stable(burst_active))); // R8

    AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_adv_n && !burst_active) |=> ($stable(addr) && !burst_active)); // R9
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .BEAT_BITS(BEAT_BITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_en_n     (clk_en_n),
    .ld_adv_n     (ld_adv_n),
    .sel          (sel),
    .ext_addr     (ext_addr),
    .order_il     (order_il),
    .addr         (addr),
    .burst_active (burst_active)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en_n = 1'b0;
    logic          ld_adv_n = 1'b1;
    logic          sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          order_il = 1'b0;
    logic [AW-1:0] addr;
    logic          burst_active;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq #(.AW(AW), .BEAT_BITS(2)) uut (
        .clk          (clk),
        .rst          (rst),
        .clk_en_n     (clk_en_n),
        .ld_adv_n     (ld_adv_n),
        .sel          (sel),
        .ext_addr     (ext_addr),
        .order_il     (order_il),
        .addr         (addr),
        .burst_active (burst_active)
    );

    logic [AW-1:0] exp_addr_q[$];
    logic          exp_act_q[$];
    string         tag_q[$];
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    logic [AW-1:0] m_addr = '0;
    logic          m_act = 1'b0;
    logic [1:0]    m_start = '0;
    logic [1:0]    m_beat = '0;

    task automatic step(input logic r, input logic cen, input logic ld, input logic s,
                        input logic [AW-1:0] ext, input logic il, input string tag);
        @(negedge clk);
        rst = r; clk_en_n = cen; ld_adv_n = ld; sel = s; ext_addr = ext; order_il = il;
        if (r) begin
            m_addr = '0; m_act = 1'b0; m_start = '0; m_beat = '0;
        end else if (!cen) begin
            if (!ld) begin
                if (s) begin
                    m_addr = ext; m_start = ext[1:0]; m_beat = '0; m_act = 1'b1;
                end else begin
                    m_act = 1'b0;
                end
            end else if (m_act) begin
                m_beat = m_beat + 2'd1;
                m_addr[1:0] = il ? (m_start ^ m_beat) : (m_start + m_beat);
            end
        end
        exp_addr_q.push_back(m_addr);
        exp_act_q.push_back(m_act);
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_addr_q.size() > 0) begin
            logic [AW-1:0] ea;
            logic          eact;
            string         t;
            ea = exp_addr_q.pop_front();
            eact = exp_act_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (addr !== ea || burst_active !== eact) begin
                failures++;
                $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
                         t, addr, burst_active, ea, eact);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1, 0, 0, 1, 17'h1ABCD, 0, "R1");
        step(1, 0, 1, 0, 17'h00000, 0, "R1");
        // R2 load, R4 linear order, R3 ext_addr ignored, R6 wrap
        step(0, 0, 0, 1, 17'h12341, 0, "R2");
        step(0, 0, 1, 1, 17'h0AAAA, 0, "R4");
        step(0, 0, 1, 0, 17'h15555, 0, "R3");
        step(0, 0, 1, 1, 17'h0AAAA, 0, "R4");
        step(0, 0, 1, 1, 17'h0AAAA, 0, "R6");
        step(0, 0, 1, 1, 17'h0AAAA, 0, "R6");
        // R5 interleaved from start 1
        step(0, 0, 0, 1, 17'h0F5E1, 1, "R2");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        step(0, 0, 1, 1, 17'h00000, 1, "R6");
        // R8 clock enable high freezes, even with a load request
        step(0, 1, 0, 1, 17'h1FFFF, 1, "R8");
        step(0, 1, 1, 1, 17'h1FFFF, 1, "R8");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        // R7 deselect ends burst, R9 advance when idle
        step(0, 0, 0, 0, 17'h1FFFF, 1, "R7");
        step(0, 0, 1, 1, 17'h1FFFF, 1, "R9");
        step(0, 0, 1, 0, 17'h00000, 1, "R9");
        // R6 no carry into upper bits, linear from start 3
        step(0, 0, 0, 1, 17'h1FFFF, 0, "R2");
        step(0, 0, 1, 1, 17'h00000, 0, "R6");
        step(0, 0, 1, 1, 17'h00000, 0, "R4");
        step(0, 0, 1, 1, 17'h00000, 0, "R4");
        step(0, 0, 1, 1, 17'h00000, 0, "R6");
        // R5 interleaved from start 2
        step(0, 0, 0, 1, 17'h00002, 1, "R2");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        step(0, 0, 1, 1, 17'h00000, 1, "R5");
        // R1 reset mid-burst
        step(1, 0, 1, 1, 17'h00000, 1, "R1");
        step(0, 0, 1, 1, 17'h00000, 1, "R9");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule